// File: doc/BRIEF.md
# Write-Combining Line Buffer

This block sits on the store path of a write-through cache, between the store source and memory. Rather than forwarding every word store to memory on its own, it gathers a run of stores that walk upward through one line, one word at a time, into a single held line. It then hands that line to memory as one burst. The burst carries the line-aligned base address, every data word of the line, and a per-word mask that tells the receiver which words to write. Streaming writers, such as a producer filling a frame of pixels in address order, so generate one burst per line instead of one write per word.

A held line leaves in one of three ways. It leaves when its last missing word arrives. It leaves when a store comes in that does not continue the run, and that store then opens a fresh line. It leaves when the caller raises an explicit flush request. A single output slot holds the outgoing burst until memory accepts it. While the slot is occupied, the store input is stalled.

Top module: `wc_line_buffer`

## Requirements
- R1: During and directly after reset, `bst_valid` is 0, `st_ready` is 1 and no line is held.
- R2: A store is sequential when a line is held, its address equals the previous accepted store's address plus 4, it lies in the same 32-byte line, and its two low address bits are 0. Sequential stores merge into the held line, and no burst is emitted while the run continues and the line is not yet full.
- R3: When an accepted store makes all 8 words of the held line valid, the line is offered as a burst on the following cycle. `bst_mask` is 8'hFF and `bst_addr` is the store address with bits [4:0] cleared. Word k of the line, at byte offset 4k, appears on `bst_data[32k+31:32k]`.
- R4: An accepted store that is not sequential while a line is held emits the held line on the next cycle, with `bst_mask` bit k set exactly for the words written. This includes a store to another line, a skipped word, or an address with non-zero low bits. The store itself becomes the first valid word of a new held line.
- R5: `flush_req` while a line is held and the output slot is free emits the held line on the next cycle with its mask. If a store is accepted in the same cycle, the store always opens a new line, even when it would otherwise have been sequential.
- R6: `flush_req` while no line is held and no store is accepted has no effect: no burst appears.
- R7: While `bst_valid` is 1 and `bst_ready` is 0, `st_ready` is 0, the burst address, data and mask stay unchanged, and `flush_req` has no effect.
- R8: A burst is taken when `bst_valid` and `bst_ready` are both 1 at a clock edge. On the next cycle `bst_valid` is 0 and `st_ready` is 1.
- R9: Each emission clears all valid bits of the held line. The next burst's mask covers only words stored after that emission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W (32) | Byte address of the store word |
| st_data | input | WORD_W (32) | Store data word |
| flush_req | input | 1 | Request to emit the held line now |
| bst_valid | output | 1 | Burst offered to memory |
| bst_ready | input | 1 | Memory accepts the burst |
| bst_addr | output | ADDR_W (32) | Line-aligned base address of the burst |
| bst_data | output | LINE_WORDS*WORD_W (256) | All words of the line, word k in slice k |
| bst_mask | output | LINE_WORDS (8) | Per-word write enable |

## Verification
The properties assume that a store which meets a low `st_ready` is simply retried, and that memory may hold `bst_ready` low for any number of cycles. Under those assumptions, the slot-hold and stall checks are fair. The stimulus keeps every store word-aligned, except in one directed case where the low bits are set deliberately. A stalled store is held unchanged until it is accepted. A random flush pulse is treated as lost if it lands while the slot is busy, and this matches the rule that a request made while the slot is busy has no effect.

// File: rtl/wcb_pkg.sv
// Shared definitions for the write-combining line buffer.
// Assumes nothing beyond a standard 1800-2017 compile order (this file first).
package wcb_pkg;

    // Action applied to the held line in one cycle
    typedef enum logic [1:0] {
        LA_HOLD  = 2'd0,
        LA_START = 2'd1,
        LA_MERGE = 2'd2,
        LA_CLEAR = 2'd3
    } line_act_e;

endpackage

// File: rtl/wcb_addr_split.sv
// Splits a store address into line base and word index and decides whether
// the store continues the held run. Assumes held_* are meaningful only when
// line_busy is high.
module wcb_addr_split #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8
) (
    input  logic [ADDR_W-1:0]                          st_addr,
    input  logic                                       line_busy,
    input  logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] held_base,
    input  logic [$clog2(LINE_WORDS)-1:0]              held_last,
    output logic [ADDR_W-$clog2(LINE_WORDS*WORD_W/8)-1:0] cur_base,
    output logic [$clog2(LINE_WORDS)-1:0]              cur_idx,
    output logic                                       is_seq
);
    localparam int unsigned BYTE_SH = $clog2(WORD_W / 8);
    localparam int unsigned IDX_W   = $clog2(LINE_WORDS);
    localparam int unsigned OFF_W   = BYTE_SH + IDX_W;

    logic aligned;
    logic not_last;
    logic next_word;

    // Field extraction and continuation test
    always_comb begin
        cur_base  = st_addr[ADDR_W-1:OFF_W];
        cur_idx   = st_addr[OFF_W-1:BYTE_SH];
        aligned   = (st_addr[BYTE_SH-1:0] == '0);
        not_last  = (held_last != IDX_W'(LINE_WORDS - 1));
        next_word = (cur_idx == IDX_W'(held_last + IDX_W'(1)));
        is_seq    = line_busy && aligned && not_last && next_word
                    && (cur_base == held_base);
    end

endmodule

// File: rtl/wcb_line_regs.sv
// Holds the line being combined: base, last written word index, per-word
// valid mask and data. Assumes at most one action per cycle from the top.
module wcb_line_regs
    import wcb_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8,
    parameter int unsigned BASE_W     = 27
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  line_act_e                      act,
    input  logic [$clog2(LINE_WORDS)-1:0]  wr_idx,
    input  logic [LINE_WORDS-1:0]          wr_onehot,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic [BASE_W-1:0]              new_base,
    output logic [BASE_W-1:0]              held_base,
    output logic [$clog2(LINE_WORDS)-1:0]  held_last,
    output logic [LINE_WORDS-1:0]          held_mask,
    output logic [LINE_WORDS*WORD_W-1:0]   held_data,
    output logic                           line_busy
);
    localparam int unsigned IDX_W = $clog2(LINE_WORDS);

    logic word_wr;

    // Store writes a data word on start or merge
    always_comb word_wr = (act == LA_START) || (act == LA_MERGE);

    // Valid mask update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_mask <= '0;
        end else begin
            case (act)
                LA_START: held_mask <= wr_onehot;
                LA_MERGE: held_mask <= held_mask | wr_onehot;
                LA_CLEAR: held_mask <= '0;
                default:  held_mask <= held_mask;
            endcase
        end
    end

    // Line base and run position update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_base <= '0;
            held_last <= '0;
        end else if (act == LA_START) begin
            held_base <= new_base;
            held_last <= wr_idx;
        end else if (act == LA_MERGE) begin
            held_last <= wr_idx;
        end
    end

    // One data register per word of the line
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_data[g*WORD_W +: WORD_W] <= '0;
            end else if (word_wr && wr_onehot[g]) begin
                held_data[g*WORD_W +: WORD_W] <= wr_data;
            end
        end
    end

    // A line is held whenever any word is valid
    always_comb line_busy = |held_mask;

    logic unused_idx;
    always_comb unused_idx = ^{IDX_W{1'b0}};

endmodule

// File: rtl/wcb_burst_slot.sv
// Single-entry output register for one line burst with valid/ready.
// Assumes load is only raised while the slot is empty.
module wcb_burst_slot #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [LINE_WORDS*WORD_W-1:0]  ld_data,
    input  logic [LINE_WORDS-1:0]         ld_mask,
    input  logic                          bst_ready,
    output logic                          bst_valid,
    output logic [ADDR_W-1:0]             bst_addr,
    output logic [LINE_WORDS*WORD_W-1:0]  bst_data,
    output logic [LINE_WORDS-1:0]         bst_mask
);

    // Slot occupancy: set on load, cleared on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_valid <= 1'b0;
        end else if (load) begin
            bst_valid <= 1'b1;
        end else if (bst_valid && bst_ready) begin
            bst_valid <= 1'b0;
        end
    end

    // Burst payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_addr <= '0;
            bst_data <= '0;
            bst_mask <= '0;
        end else if (load) begin
            bst_addr <= ld_addr;
            bst_data <= ld_data;
            bst_mask <= ld_mask;
        end
    end

endmodule

// File: rtl/wc_line_buffer.sv
// Write-combining line buffer. Merges word stores that walk upward through
// one line and emits the line as one masked burst when it fills, when a
// non-continuing store arrives, or on flush_req. Assumes the store source
// holds a store until st_ready is seen and that flush_req is retried while
// the output slot is busy.
module wc_line_buffer
    import wcb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          st_valid,
    output logic                          st_ready,
    input  logic [ADDR_W-1:0]             st_addr,
    input  logic [WORD_W-1:0]             st_data,
    input  logic                          flush_req,
    output logic                          bst_valid,
    input  logic                          bst_ready,
    output logic [ADDR_W-1:0]             bst_addr,
    output logic [LINE_WORDS*WORD_W-1:0]  bst_data,
    output logic [LINE_WORDS-1:0]         bst_mask
);
    localparam int unsigned BYTE_SH = $clog2(WORD_W / 8);
    localparam int unsigned IDX_W   = $clog2(LINE_WORDS);
    localparam int unsigned OFF_W   = BYTE_SH + IDX_W;
    localparam int unsigned BASE_W  = ADDR_W - OFF_W;
    localparam int unsigned LINE_W  = LINE_WORDS * WORD_W;

    logic [BASE_W-1:0]     cur_base;
    logic [IDX_W-1:0]      cur_idx;
    logic                  is_seq;
    logic [LINE_WORDS-1:0] cur_onehot;
    logic [BASE_W-1:0]     held_base;
    logic [IDX_W-1:0]      held_last;
    logic [LINE_WORDS-1:0] held_mask;
    logic [LINE_W-1:0]     held_data;
    logic                  line_busy;
    logic                  accept;
    logic                  flush_eff;
    logic                  start_new;
    logic                  merge;
    logic                  complete;
    logic                  brk;
    logic                  push;
    logic [LINE_WORDS-1:0] merged_mask;
    logic [LINE_W-1:0]     merged_data;
    logic [ADDR_W-1:0]     ld_addr;
    logic [LINE_W-1:0]     ld_data;
    logic [LINE_WORDS-1:0] ld_mask;
    line_act_e             act;

    wcb_addr_split #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) split_i (
        .st_addr   (st_addr),
        .line_busy (line_busy),
        .held_base (held_base),
        .held_last (held_last),
        .cur_base  (cur_base),
        .cur_idx   (cur_idx),
        .is_seq    (is_seq)
    );

    // Decode the word index into a word select
    always_comb cur_onehot = {{(LINE_WORDS-1){1'b0}}, 1'b1} << cur_idx;

    // Store handshake: stall whenever the burst slot is occupied
    always_comb begin
        st_ready = !bst_valid;
        accept   = st_valid && st_ready;
    end

    // Line decisions for this cycle
    always_comb begin
        flush_eff   = flush_req && line_busy && !bst_valid;
        brk         = accept && line_busy && !is_seq;
        start_new   = accept && (!line_busy || !is_seq || flush_req);
        merge       = accept && !start_new;
        merged_mask = held_mask | cur_onehot;
        complete    = merge && (&merged_mask);
        push        = flush_eff || brk || complete;
    end

    // Choose the action applied to the held line
    always_comb begin
        if (complete) begin
            act = LA_CLEAR;
        end else if (start_new) begin
            act = LA_START;
        end else if (merge) begin
            act = LA_MERGE;
        end else if (flush_eff) begin
            act = LA_CLEAR;
        end else begin
            act = LA_HOLD;
        end
    end

    // Line content with the current store folded in
    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_merge
        assign merged_data[g*WORD_W +: WORD_W] =
            cur_onehot[g] ? st_data : held_data[g*WORD_W +: WORD_W];
    end

    // Payload handed to the output slot
    always_comb begin
        ld_addr = {held_base, {OFF_W{1'b0}}};
        ld_data = complete ? merged_data : held_data;
        ld_mask = complete ? merged_mask : held_mask;
    end

    wcb_line_regs #(
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .BASE_W     (BASE_W)
    ) line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .wr_idx    (cur_idx),
        .wr_onehot (cur_onehot),
        .wr_data   (st_data),
        .new_base  (cur_base),
        .held_base (held_base),
        .held_last (held_last),
        .held_mask (held_mask),
        .held_data (held_data),
        .line_busy (line_busy)
    );

    wcb_burst_slot #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (push),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .ld_mask   (ld_mask),
        .bst_ready (bst_ready),
        .bst_valid (bst_valid),
        .bst_addr  (bst_addr),
        .bst_data  (bst_data),
        .bst_mask  (bst_mask)
    );

endmodule

// File: rtl/wc_line_buffer_chk.sv
// Property checker for wc_line_buffer, attached with bind below.
// Assumes a synchronous active-low reset driven from time zero.
module wc_line_buffer_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LINE_WORDS = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          st_valid,
    input logic                          st_ready,
    input logic                          bst_valid,
    input logic                          bst_ready,
    input logic [ADDR_W-1:0]             bst_addr,
    input logic [LINE_WORDS*WORD_W-1:0]  bst_data,
    input logic [LINE_WORDS-1:0]         bst_mask,
    input logic                          line_busy
);
    localparam int unsigned OFF_W = $clog2(LINE_WORDS * WORD_W / 8);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bst_valid && st_ready)); // R1

    AST_STALL_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> !st_ready); // R7

    AST_BURST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr)
            && $stable(bst_mask) && $stable(bst_data))); // R7

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_addr[OFF_W-1:0] == '0)); // R3

    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        bst_valid |-> (bst_mask != '0)); // R4

    AST_EMPTY_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_busy && !bst_valid && !st_valid) |=> !bst_valid); // R6

    AST_SLOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && bst_ready) |=> (!bst_valid && st_ready)); // R8

endmodule

bind wc_line_buffer wc_line_buffer_chk #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .bst_valid (bst_valid),
    .bst_ready (bst_ready),
    .bst_addr  (bst_addr),
    .bst_data  (bst_data),
    .bst_mask  (bst_mask),
    .line_busy (line_busy)
);

// File: tb/wc_line_buffer_tb_top.sv
`timescale 1ns/1ps
module wc_line_buffer_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic         flush_req = 1'b0;
    logic         bst_valid;
    logic         bst_ready = 1'b0;
    logic [31:0]  bst_addr;
    logic [255:0] bst_data;
    logic [7:0]   bst_mask;

    int total = 0;
    int bad = 0;

    // Reference line held by the bench
    logic         m_busy = 1'b0;
    logic [26:0]  m_base = '0;
    logic [2:0]   m_last = '0;
    logic [7:0]   m_mask = '0;
    logic [255:0] m_data = '0;
    logic [31:0]  q_addr[$];
    logic [7:0]   q_mask[$];
    logic [255:0] q_data[$];

    always #4 clk = ~clk;

    wc_line_buffer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_ready  (st_ready),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .flush_req (flush_req),
        .bst_valid (bst_valid),
        .bst_ready (bst_ready),
        .bst_addr  (bst_addr),
        .bst_data  (bst_data),
        .bst_mask  (bst_mask)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_next(input logic [31:0] a);
        return m_busy && (a[1:0] == 2'b00) && (a[31:5] == m_base)
               && (m_last != 3'd7) && (a[4:2] == m_last + 3'd1);
    endfunction

    task automatic emit_model();
        q_addr.push_back({m_base, 5'b0});
        q_mask.push_back(m_mask);
        q_data.push_back(m_data);
        m_busy = 1'b0;
        m_mask = '0;
    endtask

    // Compare a taken burst with the oldest expected line
    task automatic take_burst();
        logic [31:0]  ea;
        logic [7:0]   em;
        logic [255:0] ed;
        bit           ok;
        if (q_addr.size() == 0) begin
            check(1'b0, "R2 unexpected burst", {32'd0, bst_addr}, 64'd0);
            return;
        end
        ea = q_addr.pop_front();
        em = q_mask.pop_front();
        ed = q_data.pop_front();
        ok = (bst_addr == ea) && (bst_mask == em);
        for (int k = 0; k < 8; k++) begin
            if (em[k] && bst_data[k*32 +: 32] != ed[k*32 +: 32]) ok = 1'b0;
        end
        check(ok, "R3 R4 R9 burst addr/mask/data", {24'd0, bst_mask, bst_addr}, {24'd0, em, ea});
    endtask

    // Apply one cycle of stimulus and advance the reference line
    task automatic cyc(input bit sv, input logic [31:0] a, input logic [31:0] d,
                       input bit fr, input bit br, output bit taken);
        bit acc;
        bit nxt;
        st_valid = sv; st_addr = a; st_data = d; flush_req = fr; bst_ready = br;
        #1;
        acc = sv && st_ready;
        if (bst_valid && br) take_burst();
        nxt = is_next(a);
        if ((fr && m_busy && !bst_valid) || (acc && m_busy && !nxt)) emit_model();
        if (acc) begin
            if (!m_busy) begin
                m_busy = 1'b1;
                m_base = a[31:5];
                m_mask = 8'd1 << a[4:2];
            end else begin
                m_mask = m_mask | (8'd1 << a[4:2]);
            end
            m_last = a[4:2];
            m_data[a[4:2]*32 +: 32] = d;
            if (m_mask == 8'hFF) emit_model();
        end
        taken = acc;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input bit fr, input bit br);
        bit t;
        cyc(1'b0, 32'd0, 32'd0, fr, br, t);
    endtask

    task automatic store(input logic [31:0] a, input bit fr);
        bit t;
        cyc(1'b1, a, $urandom, fr, 1'b0, t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit          t;
        bit          hold;
        logic [31:0] ra;
        logic [31:0] rd;
        bit          rv;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(st_ready == 1'b1 && bst_valid == 1'b0, "R1 reset idle", {st_ready, bst_valid}, 2'b10);

        // Full sequential line
        for (int k = 0; k < 8; k++) begin
            store(32'h100 + 32'(4*k), 1'b0);
            if (k < 7) check(bst_valid == 1'b0, "R2 no burst mid-run", bst_valid, 0);
        end
        check(bst_valid && bst_mask == 8'hFF && bst_addr == 32'h100, "R3 full line burst",
              {bst_mask, bst_addr}, {8'hFF, 32'h100});
        idle(1'b1, 1'b0);
        idle(1'b0, 1'b0);
        check(bst_valid && !st_ready && bst_mask == 8'hFF, "R7 held burst stalls stores",
              {bst_valid, st_ready}, 2'b10);
        idle(1'b0, 1'b1);
        check(!bst_valid && st_ready, "R8 slot released", {bst_valid, st_ready}, 2'b01);
        idle(1'b0, 1'b0);
        check(!bst_valid, "R7 flush while busy had no effect", bst_valid, 0);

        // Partial run broken by another line
        store(32'h208, 1'b0);
        store(32'h20C, 1'b0);
        store(32'h300, 1'b0);
        check(bst_valid && bst_mask == 8'h0C && bst_addr == 32'h200, "R4 break on new line",
              {bst_mask, bst_addr}, {8'h0C, 32'h200});
        idle(1'b0, 1'b1);
        idle(1'b1, 1'b0);
        check(bst_valid && bst_mask == 8'h01 && bst_addr == 32'h300, "R5 explicit flush",
              {bst_mask, bst_addr}, {8'h01, 32'h300});
        idle(1'b0, 1'b1);

        // Flush with nothing held
        for (int k = 0; k < 3; k++) begin
            idle(1'b1, 1'b0);
            check(!bst_valid, "R6 empty flush ignored", bst_valid, 0);
        end

        // Valid bits cleared after an emission
        store(32'h31C, 1'b0);
        idle(1'b1, 1'b0);
        check(bst_valid && bst_mask == 8'h80 && bst_addr == 32'h300, "R9 mask cleared after flush",
              {bst_mask, bst_addr}, {8'h80, 32'h300});
        idle(1'b0, 1'b1);

        // Store and flush in the same cycle
        store(32'h400, 1'b0);
        store(32'h404, 1'b1);
        check(bst_valid && bst_mask == 8'h01 && bst_addr == 32'h400, "R5 flush with store",
              {bst_mask, bst_addr}, {8'h01, 32'h400});
        idle(1'b0, 1'b1);
        idle(1'b1, 1'b0);
        check(bst_valid && bst_mask == 8'h02 && bst_addr == 32'h400, "R5 store opened new line",
              {bst_mask, bst_addr}, {8'h02, 32'h400});
        idle(1'b0, 1'b1);

        // Skipped word and misaligned address both break the run
        store(32'h600, 1'b0);
        store(32'h608, 1'b0);
        check(bst_valid && bst_mask == 8'h01, "R4 skipped word", bst_mask, 8'h01);
        idle(1'b0, 1'b1);
        store(32'h60E, 1'b0);
        check(bst_valid && bst_mask == 8'h04 && bst_addr == 32'h600, "R4 misaligned breaks run",
              {bst_mask, bst_addr}, {8'h04, 32'h600});
        idle(1'b0, 1'b1);
        idle(1'b1, 1'b0);
        check(bst_valid && bst_mask == 8'h08, "R4 misaligned store kept", bst_mask, 8'h08);
        idle(1'b0, 1'b1);

        // Constrained random traffic, mostly sequential
        hold = 1'b0;
        ra = 32'h800;
        rd = '0;
        rv = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (!hold) begin
                int r;
                r = int'($urandom % 16);
                rv = ($urandom % 10) < 8;
                if (r < 12)      ra = ra + 32'd4;
                else if (r < 14) ra = $urandom & 32'hFFC;
                else             ra = ra + 32'd8;
                ra = ra & 32'hFFFC;
                rd = $urandom;
            end
            cyc(rv, ra, rd, ($urandom % 20) == 0, ($urandom % 10) < 6, t);
            hold = rv && !t;
        end

        // Drain everything still held
        for (int k = 0; k < 6; k++) idle(1'b1, 1'b1);
        check(q_addr.size() == 0 && !bst_valid, "R2 all stores delivered",
              q_addr.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule